// File: doc/BRIEF.md
# BCD calendar counter chain

This block keeps the running time and date of a real-time clock as eight packed-BCD bytes: seconds, minutes, hours (24-hour), day of week, date, month, year and century. A one-cycle enable pulse, issued once per second by an oscillator divider outside the block, moves the seconds forward. Each field carries into the next field when it wraps. A run input lets the time stop without losing it.

Software sets the time through a parallel load port, which writes all eight fields in one cycle. The full time is always visible on one wide snapshot output, so a reader never sees a carry half done. The block corrects the last date of each month on its own. For leap years it uses the plain divisible-by-four test on the two-digit year, which is correct up to 2100.

Top module: `bcd_calendar`

## Requirements
- R1: While rst_ni is low, and after it rises, time_o equals 64'h2000_0101_0100_0000 until the first load or advance. In that value the century is 20, year 00, month 01, date 01, weekday 01 and the time 00:00:00. The fields of time_o and load_val_i sit at these bits: century [63:56], year [55:48], month [47:40], date [39:32], weekday [31:24], hours [23:16], minutes [15:8], seconds [7:0].
- R2: An advance happens when tick_i and run_i are both high and load_i is low at a rising clock edge. The seconds field then holds its BCD successor from that edge on (for example 09 becomes 10).
- R3: If tick_i or run_i is low and load_i is low, time_o keeps its value at the edge.
- R4: When load_i is high, time_o equals load_val_i after the edge, even if an advance is requested in the same cycle.
- R5: Seconds wrap from 59 to 00 and advance the minutes. Minutes wrap from 59 to 00 and advance the hours. Hours wrap from 23 to 00 and start a new day.
- R6: On each new day the weekday counts 01 to 07 and then wraps back to 01. The weekday never changes the date.
- R7: On a new day the date wraps to 01 and advances the month. This happens after date 30 in months 04, 06, 09 and 11, and after date 31 in months 01, 03, 05, 07, 08, 10 and 12.
- R8: February wraps after 29 when the BCD year is divisible by four, which includes year 00. Otherwise it wraps after 28.
- R9: The month wraps from 12 to 01 and advances the year. The year wraps from 99 to 00 and advances the century. The century wraps from 99 to 00.
- R10: If every load holds valid BCD values in range, every nibble of time_o stays at 9 or below, and advances never leave the valid ranges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse, once per second |
| run_i | input | 1 | 1 lets ticks advance the time, 0 stops it |
| load_i | input | 1 | Parallel load strobe, takes priority over a tick |
| load_val_i | input | 64 | Values written on a load, in the field layout of R1 |
| time_o | output | 64 | Registered snapshot of all fields, in the layout of R1 |

## Verification
The assertions take for granted that every loaded value is valid, in-range BCD: each nibble is 9 or below, the weekday is 1 to 7, the month is 1 to 12, and the date is no larger than the length of its month. The block does not repair an illegal load. The bench loads only legal calendar states. It places them just before each wrap boundary, so that a single tick crosses the rollover under test. It also runs a full day of consecutive ticks from a legal start and checks every digit on every cycle.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int unsigned FIELD_W    = 8;
  localparam int unsigned NUM_FIELDS = 8;
  localparam int unsigned TIME_W     = FIELD_W * NUM_FIELDS;

  localparam int unsigned F_SEC   = 0;
  localparam int unsigned F_MIN   = 1;
  localparam int unsigned F_HOUR  = 2;
  localparam int unsigned F_WDAY  = 3;
  localparam int unsigned F_DATE  = 4;
  localparam int unsigned F_MONTH = 5;
  localparam int unsigned F_YEAR  = 6;
  localparam int unsigned F_CENT  = 7;

  typedef logic [FIELD_W-1:0] bcd_t;

  function automatic bcd_t field_first(int unsigned idx);
    return (idx == F_WDAY || idx == F_DATE || idx == F_MONTH) ? 8'h01 : 8'h00;
  endfunction

  // fixed wrap points; date limit comes from the month length logic
  function automatic bcd_t field_last(int unsigned idx);
    case (idx)
      F_SEC, F_MIN:   return 8'h59;
      F_HOUR:         return 8'h23;
      F_WDAY:         return 8'h07;
      F_DATE:         return 8'h31;
      F_MONTH:        return 8'h12;
      default:        return 8'h99;
    endcase
  endfunction
endpackage

// File: rtl/cal_bcd_step.sv
module cal_bcd_step
  import cal_pkg::*;
#(
  parameter bcd_t FIRST = 8'h00
) (
  input  bcd_t val_i,
  input  bcd_t last_i,
  output bcd_t nxt_o,
  output logic wrap_o
);
  always_comb begin
    wrap_o = (val_i == last_i);
    if (wrap_o)
      nxt_o = FIRST;
    else if (val_i[3:0] >= 4'h9)
      nxt_o = {val_i[7:4] + 4'h1, 4'h0};
    else
      nxt_o = {val_i[7:4], val_i[3:0] + 4'h1};
  end
endmodule

// File: rtl/cal_month_len.sv
module cal_month_len
  import cal_pkg::*;
(
  input  bcd_t       month_i,
  input  logic       year_tens_lsb_i,
  input  logic [3:0] year_ones_i,
  output bcd_t       last_o
);
  logic [1:0] mod4;
  logic       leap;

  // 10*t + u mod 4 == (2*t[0] + u) mod 4
  always_comb begin
    mod4 = year_ones_i[1:0] + {year_tens_lsb_i, 1'b0};
    leap = (mod4 == 2'b00);
    case (month_i)
      8'h02:                      last_o = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_o = 8'h30;
      default:                    last_o = 8'h31;
    endcase
  end
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
  import cal_pkg::*;
#(
  parameter logic [TIME_W-1:0] RESET_TIME = 64'h2000_0101_0100_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              run_i,
  input  logic              load_i,
  input  logic [TIME_W-1:0] load_val_i,
  output logic [TIME_W-1:0] time_o
);
  logic [TIME_W-1:0] time_q;
  bcd_t cur  [NUM_FIELDS];
  bcd_t nxt  [NUM_FIELDS];
  bcd_t lim  [NUM_FIELDS];
  logic [NUM_FIELDS-1:0] wrap;
  logic [NUM_FIELDS-1:0] en;
  bcd_t month_last;
  logic unused_wrap;

  cal_month_len u_month_len (
    .month_i        (cur[F_MONTH]),
    .year_tens_lsb_i(cur[F_YEAR][4]),
    .year_ones_i    (cur[F_YEAR][3:0]),
    .last_o         (month_last)
  );

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    assign cur[i] = time_q[i*FIELD_W +: FIELD_W];
    cal_bcd_step #(.FIRST(field_first(i))) u_step (
      .val_i (cur[i]),
      .last_i(lim[i]),
      .nxt_o (nxt[i]),
      .wrap_o(wrap[i])
    );
  end

  always_comb begin
    for (int unsigned i = 0; i < NUM_FIELDS; i++) lim[i] = field_last(i);
    lim[F_DATE] = month_last;
  end

  // carry chain; weekday and date both hang off the midnight carry
  always_comb begin
    en[F_SEC]   = tick_i & run_i;
    en[F_MIN]   = en[F_SEC]   & wrap[F_SEC];
    en[F_HOUR]  = en[F_MIN]   & wrap[F_MIN];
    en[F_WDAY]  = en[F_HOUR]  & wrap[F_HOUR];
    en[F_DATE]  = en[F_HOUR]  & wrap[F_HOUR];
    en[F_MONTH] = en[F_DATE]  & wrap[F_DATE];
    en[F_YEAR]  = en[F_MONTH] & wrap[F_MONTH];
    en[F_CENT]  = en[F_YEAR]  & wrap[F_YEAR];
  end

  assign unused_wrap = wrap[F_WDAY] ^ wrap[F_CENT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      time_q <= RESET_TIME;
    end else if (load_i) begin
      time_q <= load_val_i;
    end else begin
      for (int unsigned i = 0; i < NUM_FIELDS; i++)
        if (en[i]) time_q[i*FIELD_W +: FIELD_W] <= nxt[i];
    end
  end

  assign time_o = time_q;
endmodule

// File: rtl/cal_checker.sv
module cal_checker
  import cal_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              run_i,
  input logic              load_i,
  input logic [TIME_W-1:0] load_val_i,
  input logic [TIME_W-1:0] time_o
);
  logic adv;
  logic eod;
  logic bad_digit;
  bcd_t sec, mins, wday, date, month, year;

  assign adv   = tick_i & run_i & ~load_i;
  assign sec   = time_o[7:0];
  assign mins  = time_o[15:8];
  assign wday  = time_o[31:24];
  assign date  = time_o[39:32];
  assign month = time_o[47:40];
  assign year  = time_o[55:48];
  assign eod   = (time_o[23:0] == 24'h23_5959);

  always_comb begin
    bad_digit = 1'b0;
    for (int i = 0; i < TIME_W / 4; i++)
      if (time_o[i*4 +: 4] > 4'h9) bad_digit = 1'b1;
  end

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !(tick_i && run_i)) |=> $stable(time_o));

  p_load_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (time_o == $past(load_val_i)));

  p_sec_moves_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv |=> (sec != $past(sec)));

  p_min_carry_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && sec == 8'h59) |=> (sec == 8'h00 && mins != $past(mins)));

  p_wday_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wday >= 8'h01 && wday <= 8'h07));

  p_april_end_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && eod && month == 8'h04 && date == 8'h30) |=> (date == 8'h01 && month == 8'h05));

  p_feb29_end_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && eod && month == 8'h02 && date == 8'h29) |=> (date == 8'h01 && month == 8'h03));

  p_year_carry_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && eod && month == 8'h12 && date == 8'h31 && year == 8'h99)
      |=> (year == 8'h00 && time_o[63:56] != $past(time_o[63:56])));

  p_bcd_digits_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bad_digit);
endmodule

bind bcd_calendar cal_checker i_cal_checker (.*);

// File: tb/test_bcd_calendar.sv
module test_bcd_calendar;
  localparam int unsigned TW       = 64;
  localparam logic [TW-1:0] RST_T  = 64'h2000_0101_0100_0000;
  localparam int unsigned WATCHDOG = 190000;

  typedef struct packed {
    logic [TW-1:0] start;
    logic          run;
    logic [TW-1:0] expect_t;
  } vec_t;

  localparam int unsigned NV = 22;
  localparam vec_t VEC [NV] = '{
    '{64'h2000_0101_0100_0000, 1'b1, 64'h2000_0101_0100_0001}, // R2
    '{64'h2000_0101_0100_0009, 1'b1, 64'h2000_0101_0100_0010}, // R2
    '{64'h2000_0101_0100_0059, 1'b1, 64'h2000_0101_0100_0100}, // R5
    '{64'h2000_0101_0110_5959, 1'b1, 64'h2000_0101_0111_0000}, // R5
    '{64'h2024_0315_0523_5959, 1'b1, 64'h2024_0316_0600_0000}, // R5 R6
    '{64'h2024_0316_0723_5959, 1'b1, 64'h2024_0317_0100_0000}, // R6
    '{64'h2024_0315_0512_3456, 1'b0, 64'h2024_0315_0512_3456}, // R3
    '{64'h2023_0430_0223_5959, 1'b1, 64'h2023_0501_0300_0000}, // R7
    '{64'h2023_0930_0123_5959, 1'b1, 64'h2023_1001_0200_0000}, // R7
    '{64'h2023_1130_0423_5959, 1'b1, 64'h2023_1201_0500_0000}, // R7
    '{64'h2023_0130_0223_5959, 1'b1, 64'h2023_0131_0300_0000}, // R7
    '{64'h2023_0131_0323_5959, 1'b1, 64'h2023_0201_0400_0000}, // R7
    '{64'h2023_0731_0123_5959, 1'b1, 64'h2023_0801_0200_0000}, // R7
    '{64'h2023_0228_0223_5959, 1'b1, 64'h2023_0301_0300_0000}, // R8
    '{64'h2024_0228_0223_5959, 1'b1, 64'h2024_0229_0300_0000}, // R8
    '{64'h2024_0229_0323_5959, 1'b1, 64'h2024_0301_0400_0000}, // R8
    '{64'h2000_0228_0223_5959, 1'b1, 64'h2000_0229_0300_0000}, // R8
    '{64'h2012_0228_0223_5959, 1'b1, 64'h2012_0229_0300_0000}, // R8
    '{64'h2010_0228_0223_5959, 1'b1, 64'h2010_0301_0300_0000}, // R8
    '{64'h2023_1231_0123_5959, 1'b1, 64'h2024_0101_0200_0000}, // R9
    '{64'h2099_1231_0523_5959, 1'b1, 64'h2100_0101_0600_0000}, // R9
    '{64'h9999_1231_0523_5959, 1'b1, 64'h0000_0101_0600_0000}  // R9
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic          run = 1'b0;
  logic          load = 1'b0;
  logic [TW-1:0] load_val = '0;
  logic [TW-1:0] time_w;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bcd_calendar i_bcd_calendar (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .tick_i    (tick),
    .run_i     (run),
    .load_i    (load),
    .load_val_i(load_val),
    .time_o    (time_w)
  );

  task automatic check(input string tag, input logic [TW-1:0] got, input logic [TW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge with strobes cleared
  task automatic drive(input logic ld, input logic [TW-1:0] v, input logic tk, input logic rn);
    load = ld; load_val = v; tick = tk; run = rn;
    @(negedge clk);
    load = 1'b0; tick = 1'b0;
  endtask

  function automatic bit has_bad_digit(input logic [TW-1:0] t);
    for (int i = 0; i < TW / 4; i++)
      if (t[i*4 +: 4] > 4'h9) return 1'b1;
    return 1'b0;
  endfunction

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    bit sweep_bad;
    load_val = 64'hFFFF_FFFF_FFFF_FFFF;
    repeat (3) @(negedge clk);
    check("R1 in reset", time_w, RST_T);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", time_w, RST_T);

    for (int v = 0; v < NV; v++) begin
      drive(1'b1, VEC[v].start, 1'b0, 1'b0);
      drive(1'b0, '0, 1'b1, VEC[v].run);
      check($sformatf("vector %0d", v), time_w, VEC[v].expect_t);
    end

    // R3: tick without run, run without tick
    drive(1'b1, 64'h2031_0606_0411_2233, 1'b0, 1'b0);
    drive(1'b0, '0, 1'b1, 1'b0);
    check("R3 tick while stopped", time_w, 64'h2031_0606_0411_2233);
    drive(1'b0, '0, 1'b0, 1'b1);
    check("R3 run without tick", time_w, 64'h2031_0606_0411_2233);

    // R4: load beats a simultaneous advance
    drive(1'b1, 64'h2045_1231_0723_5959, 1'b1, 1'b1);
    check("R4 load over tick", time_w, 64'h2045_1231_0723_5959);
    drive(1'b0, '0, 1'b1, 1'b1);
    check("R4 first tick after load", time_w, 64'h2046_0101_0100_0000);

    // R10 plus R5/R8: one full day of consecutive ticks across Feb 28 of a leap year
    drive(1'b1, 64'h2024_0228_0300_0000, 1'b0, 1'b0);
    sweep_bad = 1'b0;
    tick = 1'b1; run = 1'b1;
    repeat (86400) begin
      @(negedge clk);
      if (has_bad_digit(time_w)) sweep_bad = 1'b1;
    end
    tick = 1'b0;
    check("R10 digits stayed BCD", {63'd0, sweep_bad}, 64'd0);
    check("R8 R5 one day later", time_w, 64'h2024_0229_0400_0000);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule